// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is an SMBus target that serves a small byte-wide register file. A fast system clock samples SCL and SDA. Each line passes through its own synchronizer, and the block detects START, repeated START and STOP from the synchronized values. The target answers to one 7-bit address. A two-bit strap input selects that address, and the block reads the strap once, when reset is released.

A host writes a block as follows. It sends the address with the write bit, then a starting index, then a byte count, then the data bytes. The target stores the data bytes at consecutive indices. To read, the host writes the starting index, issues a repeated START and sends the address with the read bit. The target then sends a count byte, taken from a register the host can write, followed by register bytes from the index upward.

SDA is open-drain: the target only ever pulls the line low, through an output-enable. Each stored byte also appears as a one-cycle strobe that carries its index and value.

Top module: `smb_regblk`

## Requirements
- R1: The strap is sampled on the first clock after reset is released, and the device address is chosen from it: strap 00 gives 0x6B, 01 gives 0x6C, 10 gives 0x6D, and 11 gives 0x6B. Later changes to the strap have no effect until the next reset.
- R2: After reset, SDA is released (sda_oe = 0). Registers 0, 1 and 2 read 0xFF, register 8 reads 0x07, and every other register reads 0x00.
- R3: In a matching write, the target ACKs the address byte (8th bit 0), the index byte, the count byte X, and each of the first X data bytes. Each of those data bytes produces exactly one wr_stb pulse carrying its index and value, in bus order.
- R4: The index advances by one after each stored or sent byte and wraps from 15 to 0.
- R5: In a read (index write, repeated START, address with 8th bit 1), the target first sends the value of register 8, then registers N, N+1, and so on. Each byte goes out MSB first.
- R6: Register 8 is writable like any other register, and a write to it changes the count byte returned by later reads.
- R7: A byte at address time that does not match the device address is not ACKed. The target then ignores the bus, stores nothing and drives nothing, until the next START.
- R8: When the host NACKs a byte the target sent, the target leaves SDA released and stops sending.
- R9: A START or STOP that arrives in the middle of a byte abandons that byte without storing it. After a START the target receives a fresh address byte.
- R10: Data bytes after the first X in a write are not ACKed and are not stored.
- R11: The target changes sda_oe only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset |
| strap | input | 2 | Address select, sampled once after reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_stb | output | 1 | One-cycle pulse per stored byte |
| wr_idx | output | 4 | Index of the stored byte |
| wr_dat | output | 8 | Value of the stored byte |

## Verification
The bench wraps the index past 15, both when writing and when reading. A design that carried the index past 15 would place bytes where the bench does not expect them. It sends more data bytes than the count allows; a target that ignored the count would ACK the extra byte and pulse the strobe. It cuts bytes short with a STOP and with a repeated START. An engine that kept its bit counter across those conditions would store a partial byte or misread the next address. It also moves the strap after reset and reads back a rewritten count register. An address that follows the strap live, or a count byte drawn from a fixed value, shows up as a wrong ACK or a wrong first read byte.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } smb_state_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_INDEX,
    RL_COUNT,
    RL_DATA
  } smb_role_e;

  // Strap code to device address; code 3 falls back to the base address.
  function automatic logic [6:0] addr_from_strap(input logic [1:0] s, input logic [6:0] base);
    case (s)
      2'b01:   return base + 7'd1;
      2'b10:   return base + 7'd2;
      default: return base;
    endcase
  endfunction

  // Reset value of register i.
  function automatic logic [7:0] reg_reset_val(input int i, input int cnt_idx, input logic [7:0] cnt_rst);
    if (i < 3)             return 8'hFF;
    else if (i == cnt_idx) return cnt_rst;
    else                   return 8'h00;
  endfunction

endpackage

// File: rtl/smb_insync.sv
`timescale 1ns/1ps
module smb_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      prev  <= chain[STAGES-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/smb_regs.sv
`timescale 1ns/1ps
module smb_regs
  import smb_pkg::*;
#(
  parameter int         NREG    = 16,
  parameter int         CNT_IDX = 8,
  parameter logic [7:0] CNT_RST = 8'h07,
  localparam int        IDXW    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [7:0]      wdat,
  input  logic [IDXW-1:0] ridx,
  output logic [7:0]      rdat,
  output logic [7:0]      cnt_dat
);
  logic [7:0] mem     [NREG];
  logic [7:0] rst_val [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_rst
    assign rst_val[g] = reg_reset_val(g, CNT_IDX, CNT_RST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= rst_val[i];
    end else if (we) begin
      mem[widx] <= wdat;
    end
  end

  assign rdat    = mem[ridx];
  assign cnt_dat = mem[CNT_IDX];

  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx == IDXW'(CNT_IDX)) |=> (cnt_dat == $past(wdat))); // R6
endmodule

// File: rtl/smb_engine.sv
`timescale 1ns/1ps
module smb_engine
  import smb_pkg::*;
#(
  parameter int         IDXW      = 4,
  parameter logic [6:0] BASE_ADDR = 7'h6B
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      strap,
  input  logic            scl_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            sda_s,
  input  logic            sda_rise,
  input  logic            sda_fall,
  input  logic [7:0]      rd_dat,
  input  logic [7:0]      cnt_dat,
  output logic [IDXW-1:0] rd_idx,
  output logic            sda_oe,
  output logic            wr_stb,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_dat
);
  function automatic logic [IDXW-1:0] idx_next(input logic [IDXW-1:0] i);
    return i + 1'b1;
  endfunction

  logic            armed;
  logic [6:0]      dev_addr;
  smb_state_e      state;
  smb_role_e       role;
  logic [3:0]      bitcnt;
  logic [7:0]      sh;
  logic [IDXW-1:0] idx_q;
  logic [7:0]      rem_q;
  logic            rw_q;
  logic            host_ack;

  // named events for the assertions
  logic start_det, stop_det, byte_in;
  assign start_det = sda_fall & scl_s;
  assign stop_det  = sda_rise & scl_s;
  assign byte_in   = (state == ST_RX) & scl_fall & (bitcnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      dev_addr <= BASE_ADDR;
    end else if (!armed) begin
      armed    <= 1'b1;
      dev_addr <= addr_from_strap(strap, BASE_ADDR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      role     <= RL_ADDR;
      bitcnt   <= '0;
      sh       <= '0;
      idx_q    <= '0;
      rem_q    <= '0;
      rw_q     <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_idx   <= '0;
      wr_dat   <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        state  <= ST_RX;
        role   <= RL_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_in) begin
              state  <= ST_RXACK;
              sda_oe <= 1'b1;
              case (role)
                RL_ADDR: begin
                  if (sh[7:1] == dev_addr) begin
                    rw_q <= sh[0];
                    role <= RL_INDEX;
                  end else begin
                    state  <= ST_IDLE;
                    sda_oe <= 1'b0;
                  end
                end
                RL_INDEX: begin
                  idx_q <= sh[IDXW-1:0];
                  role  <= RL_COUNT;
                end
                RL_COUNT: begin
                  rem_q <= sh;
                  role  <= RL_DATA;
                end
                default: begin
                  if (rem_q != 8'd0) begin
                    wr_stb <= 1'b1;
                    wr_idx <= idx_q;
                    wr_dat <= sh;
                    idx_q  <= idx_next(idx_q);
                    rem_q  <= rem_q - 8'd1;
                  end else begin
                    state  <= ST_IDLE;
                    sda_oe <= 1'b0;
                  end
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw_q) begin
                state  <= ST_TX;
                sh     <= cnt_dat;
                sda_oe <= ~cnt_dat[7];
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                state  <= ST_TXACK;
                sda_oe <= 1'b0;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                state  <= ST_TX;
                bitcnt <= '0;
                sh     <= rd_dat;
                sda_oe <= ~rd_dat[7];
                idx_q  <= idx_next(idx_q);
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_idx = idx_q;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed)) |-> $stable(dev_addr)); // R1
  AST_WSTB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R7
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_TXACK && state == ST_IDLE) |-> !sda_oe); // R8
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_RX && bitcnt == 4'd0 && role == RL_ADDR)); // R9
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE)); // R9
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s)); // R11
endmodule

// File: rtl/smb_regblk.sv
`timescale 1ns/1ps
module smb_regblk #(
  parameter int         NREG        = 16,
  parameter int         CNT_IDX     = 8,
  parameter logic [7:0] CNT_RST     = 8'h07,
  parameter logic [6:0] BASE_ADDR   = 7'h6B,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              strap,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  output logic                    wr_stb,
  output logic [$clog2(NREG)-1:0] wr_idx,
  output logic [7:0]              wr_dat
);
  localparam int IDXW = $clog2(NREG);

  logic [1:0] ln_in, ln_q, ln_rise, ln_fall;
  assign ln_in = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    smb_insync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ln_in[g]),
      .q    (ln_q[g]),
      .rise (ln_rise[g]),
      .fall (ln_fall[g])
    );
  end

  logic [IDXW-1:0] rd_idx;
  logic [7:0]      rd_dat, cnt_dat;

  smb_engine #(.IDXW(IDXW), .BASE_ADDR(BASE_ADDR)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap   (strap),
    .scl_s   (ln_q[0]),
    .scl_rise(ln_rise[0]),
    .scl_fall(ln_fall[0]),
    .sda_s   (ln_q[1]),
    .sda_rise(ln_rise[1]),
    .sda_fall(ln_fall[1]),
    .rd_dat  (rd_dat),
    .cnt_dat (cnt_dat),
    .rd_idx  (rd_idx),
    .sda_oe  (sda_oe),
    .wr_stb  (wr_stb),
    .wr_idx  (wr_idx),
    .wr_dat  (wr_dat)
  );

  smb_regs #(.NREG(NREG), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_stb),
    .widx   (wr_idx),
    .wdat   (wr_dat),
    .ridx   (rd_idx),
    .rdat   (rd_dat),
    .cnt_dat(cnt_dat)
  );
endmodule

// File: tb/sim_smb_regblk.sv
`timescale 1ns/1ps
module sim_smb_regblk;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap = 2'b00;
  logic       host_scl = 1'b1;
  logic       host_sda = 1'b1;
  logic       sda_oe, wr_stb;
  logic [3:0] wr_idx;
  logic [7:0] wr_dat;
  wire        sda_line = host_sda & ~sda_oe;

  always #10 clk = ~clk;

  smb_regblk u0 (
    .clk(clk), .rst_n(rst_n), .strap(strap), .scl_i(host_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_dat(wr_dat)
  );

  int         n_chk = 0;
  int         n_bad = 0;
  logic [7:0] mdl [16];
  logic [7:0] wbuf [16];
  logic [11:0] exp_q [$];
  logic       oe_prev = 1'b0;

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic qw(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [6:0] bench_addr(input logic [1:0] s);
    logic [6:0] t [4];
    t[0] = 7'h6B; t[1] = 7'h6C; t[2] = 7'h6D; t[3] = 7'h6B;
    return t[s];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    mdl[0] = 8'hFF; mdl[1] = 8'hFF; mdl[2] = 8'hFF; mdl[8] = 8'h07;
  endtask

  // scoreboard monitor: every strobe must match the oldest expected item
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (exp_q.size() == 0) chk_eq("R3 unexpected strobe", {wr_idx, wr_dat}, 0);
      else chk_eq("R3 strobe order", {wr_idx, wr_dat}, exp_q.pop_front());
    end
  end

  // R11: an output-enable change must find SCL low
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev) chk_eq("R11 oe change with SCL high", host_scl, 0);
    oe_prev = sda_oe;
  end

  task automatic do_reset(input logic [1:0] s);
    rst_n = 1'b0; strap = s; host_scl = 1'b1; host_sda = 1'b1;
    qw(5);
    rst_n = 1'b1;
    qw(3);
    model_reset();
    chk_eq("R2 sda released after reset", sda_oe, 0);
  endtask

  task automatic start_c();
    host_sda = 1'b1; qw(Q); host_scl = 1'b1; qw(Q); host_sda = 1'b0; qw(Q); host_scl = 1'b0; qw(Q);
  endtask

  task automatic stop_c();
    host_sda = 1'b0; qw(Q); host_scl = 1'b1; qw(Q); host_sda = 1'b1; qw(Q);
  endtask

  task automatic send_bit(input logic b);
    host_sda = b; qw(Q); host_scl = 1'b1; qw(Q); host_scl = 1'b0; qw(Q);
  endtask

  task automatic get_bit(output logic b);
    host_sda = 1'b1; qw(Q); host_scl = 1'b1; qw(Q/2); b = sda_line; qw(Q/2); host_scl = 1'b0; qw(Q);
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] v);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      v[i] = x;
    end
    send_bit(~give_ack);
  endtask

  task automatic wr_block(input logic [6:0] a, input int idx, input int cnt, input int nb, input string req);
    logic ack;
    int   p;
    start_c();
    write_byte({a, 1'b0}, ack); chk_eq({req, " addr ack"}, ack, 1);
    write_byte(8'(idx), ack);   chk_eq({req, " index ack"}, ack, 1);
    write_byte(8'(cnt), ack);   chk_eq({req, " count ack"}, ack, 1);
    p = idx;
    for (int k = 0; k < nb; k++) begin
      if (k < cnt) exp_q.push_back({4'(p), wbuf[k]});
      write_byte(wbuf[k], ack);
      chk_eq({req, " data ack"}, ack, (k < cnt) ? 1 : 0);
      if (k >= cnt) break;
      mdl[p] = wbuf[k];
      p = (p + 1) % 16;
    end
    stop_c();
  endtask

  task automatic rd_block(input logic [6:0] a, input int idx, input int nb, input string req);
    logic       ack;
    logic [7:0] v;
    start_c();
    write_byte({a, 1'b0}, ack); chk_eq({req, " addr ack"}, ack, 1);
    write_byte(8'(idx), ack);   chk_eq({req, " index ack"}, ack, 1);
    start_c();
    write_byte({a, 1'b1}, ack); chk_eq({req, " read addr ack"}, ack, 1);
    read_byte(nb > 0, v);
    chk_eq({req, " R5 count byte"}, v, mdl[8]);
    for (int k = 0; k < nb; k++) begin
      read_byte(k < nb - 1, v);
      chk_eq({req, " R5 data byte"}, v, mdl[(idx + k) % 16]);
    end
    qw(2);
    chk_eq({req, " R8 released after NACK"}, sda_oe, 0);
    stop_c();
  endtask

  initial begin
    logic ack;
    do_reset(2'b01);
    strap = 2'b10;                         // R1: must not move the address
    rd_block(7'h6C, 0, 16, "R2 reset contents");

    // R7 / R1: the live strap value's address must be ignored
    start_c();
    write_byte({7'h6D, 1'b0}, ack); chk_eq("R1 R7 foreign addr nack", ack, 0);
    write_byte(8'h03, ack);         chk_eq("R7 ignored byte nack", ack, 0);
    write_byte(8'h01, ack);
    write_byte(8'h55, ack);
    chk_eq("R7 sda untouched", sda_oe, 0);
    stop_c();
    rd_block(7'h6C, 3, 1, "R7 register unchanged");

    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
    wr_block(7'h6C, 3, 4, 4, "R3 block write");
    rd_block(7'h6C, 3, 4, "R5 read back");

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_block(7'h6C, 14, 4, 4, "R4 write wrap");
    rd_block(7'h6C, 14, 4, "R4 read wrap");

    wbuf[0] = 8'h03;
    wr_block(7'h6C, 8, 1, 1, "R6 count write");
    rd_block(7'h6C, 0, 3, "R6 new count");

    wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
    wr_block(7'h6C, 10, 1, 2, "R10 excess byte");
    rd_block(7'h6C, 10, 2, "R10 excess not stored");

    // R9: STOP inside a data byte
    start_c();
    write_byte({7'h6C, 1'b0}, ack);
    write_byte(8'h05, ack);
    write_byte(8'h02, ack);
    exp_q.push_back({4'h5, 8'h77});
    write_byte(8'h77, ack); chk_eq("R9 first byte ack", ack, 1);
    mdl[5] = 8'h77;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    stop_c();
    chk_eq("R9 idle after stop", sda_oe, 0);
    // R9: repeated START inside a byte, then a full read
    start_c();
    write_byte({7'h6C, 1'b0}, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    rd_block(7'h6C, 5, 2, "R9 after aborts");

    do_reset(2'b11);
    rd_block(7'h6B, 0, 1, "R1 strap 11");
    do_reset(2'b10);
    rd_block(7'h6D, 8, 1, "R1 strap 10");
    start_c();
    write_byte({7'h6B, 1'b0}, ack); chk_eq("R1 other addr nack", ack, 0);
    stop_c();

    qw(4);
    chk_eq("R3 all strobes seen", exp_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end
endmodule